// File: doc/BRIEF.md
# Per-Hart Machine Timer Compare Unit

This block keeps one free-running 64-bit time count for a small multi-hart system, plus one 64-bit compare value for each hart. Each hart has its own level interrupt output. That output stays high for as long as the hart's compare value is at or below the current count. The count advances only in cycles where `tick_en` is high. The time base therefore comes from whatever pulse source the integrator wires to that pin, not from the bus clock rate.

Software reaches the unit through a 32-bit word bus that uses a valid/ready request and a one-cycle response pulse:

- A request is accepted on a rising edge where `bus_valid` and `bus_ready` are both high.
- `bus_ready` is low during reset and high at all other times. A requester holding `bus_valid` high while `bus_ready` is low simply waits.
- Every accepted request produces exactly one `rsp_valid` pulse in the next cycle. `rsp_rdata` carries the read word for a read and zero for a write, and is meaningful only while `rsp_valid` is high.
- There is no back-pressure on the response side.

Each 64-bit compare value is written as two independent 32-bit halves. The time count can be read but not written.

Top module: `hart_timer`

## Requirements
- R1: Reset clears the time count and every compare value to zero, and holds every interrupt output low and `bus_ready` low while reset is asserted.
- R2: The time count increments by exactly one on each rising edge where `tick_en` is high, and holds otherwise.
- R3: A read at `TIME_BASE` returns bits 31:0 of the count and a read at `TIME_BASE+4` returns bits 63:32. The value returned is the count as it stood in the cycle the read was accepted.
- R4: Hart i's compare value sits at `CMP_BASE + 8*i`. Bits 31:0 are at byte offset 0 of that slot and bits 63:32 at byte offset 4. Data is little-endian: bit 0 of `bus_wdata` lands in the lowest bit of the addressed half, and reads return the stored half unchanged.
- R5: Writing one half of a compare value leaves the other half of that value, and every other hart's value, unchanged.
- R6: Interrupt output i is a register. In each cycle it equals the unsigned test (compare value of hart i ≤ time count) as it held in the previous cycle.
- R7: Writes to either word of the time count have no effect on the count.
- R8: Reads of any address outside the compare slots and the two time words return zero. This includes offsets 1–3 and 5–7 inside a compare slot. Writes to such addresses change no stored value.
- R9: Each accepted request is followed by exactly one `rsp_valid` pulse on the next cycle, and a write's response carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-advance enable, sampled each clock |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request can be accepted |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the 32-bit word |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Read data, zero for writes |
| irq_o | output | HARTS | Per-hart timer interrupt level |

## Verification
The bench builds the unit with three harts, an 8-bit address, the compare slots at 0x40 and the time words at 0x20. This small space lets every one of the 256 addresses be read and checked against an arithmetic model.

The bench also writes all-ones to every unmapped address, then confirms that every compare half and the count are unchanged. Holding the count still lets each hart's compare value be placed exactly one below, at, and one above the count. A single-tick sweep then walks the count across staggered compare values for all three harts.

// File: rtl/hart_timer_pkg.sv
package hart_timer_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 64;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CMP_LO,
    SEL_CMP_HI,
    SEL_TIME_LO,
    SEL_TIME_HI
  } reg_sel_e;
endpackage

// File: rtl/htm_decode.sv
module htm_decode
  import hart_timer_pkg::*;
#(
  parameter int HARTS = 2,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CMP_BASE = '0,
  parameter logic [ADDR_W-1:0] TIME_BASE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [HARTS-1:0]  hit
);
  localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(HARTS * 8);
  localparam logic [ADDR_W-1:0] TIME_HI_ADDR = TIME_BASE + ADDR_W'(4);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W:0]   off_x;
  logic              in_cmp;

  assign off    = addr - CMP_BASE;
  assign off_x  = {1'b0, off};
  assign in_cmp = (addr >= CMP_BASE) && (off_x < SPAN);

  for (genvar g = 0; g < HARTS; g++) begin : g_hit
    assign hit[g] = in_cmp && (off[ADDR_W-1:3] == (ADDR_W-3)'(g));
  end

  always_comb begin
    sel = SEL_NONE;
    if (in_cmp) begin
      if (off[2:0] == 3'd0)      sel = SEL_CMP_LO;
      else if (off[2:0] == 3'd4) sel = SEL_CMP_HI;
    end else if (addr == TIME_BASE) begin
      sel = SEL_TIME_LO;
    end else if (addr == TIME_HI_ADDR) begin
      sel = SEL_TIME_HI;
    end
  end
endmodule

// File: rtl/htm_counter.sv
module htm_counter
  import hart_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  output logic [CNT_W-1:0] count_q
);
  always_ff @(posedge clk) begin
    if (rst)          count_q <= '0;
    else if (tick_en) count_q <= count_q + CNT_W'(1);
  end
endmodule

// File: rtl/htm_cmp_slot.sv
module htm_cmp_slot
  import hart_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  input  logic [CNT_W-1:0]  now,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_lo) cmp_q[WORD_W-1:0]     <= wdata;
      if (wr_hi) cmp_q[CNT_W-1:WORD_W] <= wdata;
      irq_q <= (cmp_q <= now);
    end
  end
endmodule

// File: rtl/hart_timer.sv
module hart_timer
  import hart_timer_pkg::*;
#(
  parameter int HARTS = 2,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CMP_BASE = '0,
  parameter logic [ADDR_W-1:0] TIME_BASE = ADDR_W'(16'hBFF8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic [HARTS-1:0]  irq_o
);
  logic                   accept;
  logic                   wr_acc;
  reg_sel_e               sel;
  logic [HARTS-1:0]       hit;
  logic [CNT_W-1:0]       time_q;
  logic [HARTS*CNT_W-1:0] cmp_flat;
  logic [WORD_W-1:0]      rd_word;

  assign accept = bus_valid && bus_ready;
  assign wr_acc = accept && bus_we;

  htm_decode #(
    .HARTS(HARTS), .ADDR_W(ADDR_W), .CMP_BASE(CMP_BASE), .TIME_BASE(TIME_BASE)
  ) u_dec (
    .addr(bus_addr), .sel(sel), .hit(hit)
  );

  htm_counter u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .count_q(time_q)
  );

  for (genvar h = 0; h < HARTS; h++) begin : g_slot
    htm_cmp_slot u_slot (
      .clk  (clk),
      .rst  (rst),
      .wr_lo(wr_acc && hit[h] && (sel == SEL_CMP_LO)),
      .wr_hi(wr_acc && hit[h] && (sel == SEL_CMP_HI)),
      .wdata(bus_wdata),
      .now  (time_q),
      .cmp_q(cmp_flat[h*CNT_W +: CNT_W]),
      .irq_q(irq_o[h])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int h = 0; h < HARTS; h++) begin
      if (hit[h] && sel == SEL_CMP_LO) rd_word = rd_word | cmp_flat[h*CNT_W +: WORD_W];
      if (hit[h] && sel == SEL_CMP_HI) rd_word = rd_word | cmp_flat[h*CNT_W+WORD_W +: WORD_W];
    end
    if (sel == SEL_TIME_LO) rd_word = time_q[WORD_W-1:0];
    if (sel == SEL_TIME_HI) rd_word = time_q[CNT_W-1:WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ready <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      bus_ready <= 1'b1;
      rsp_valid <= accept;
      if (accept) rsp_rdata <= bus_we ? '0 : rd_word;
    end
  end
endmodule

// File: rtl/htm_checker.sv
module htm_checker
  import hart_timer_pkg::*;
#(
  parameter int HARTS = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   tick_en,
  input logic                   bus_valid,
  input logic                   bus_ready,
  input logic                   bus_we,
  input logic                   rsp_valid,
  input logic [WORD_W-1:0]      rsp_rdata,
  input logic [CNT_W-1:0]       time_q,
  input logic [HARTS*CNT_W-1:0] cmp_flat,
  input logic [HARTS-1:0]       irq_o
);
  logic             armed;
  logic [HARTS-1:0] due;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  always_comb begin
    for (int h = 0; h < HARTS; h++) due[h] = cmp_flat[h*CNT_W +: CNT_W] <= time_q;
  end

  // R9
  acc_gives_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_ready) |=> rsp_valid);
  // R9
  idle_no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && bus_ready) |=> !rsp_valid);
  // R9
  wr_rsp_zero_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (rsp_valid && $past(bus_we)) |-> (rsp_rdata == '0));
  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> (time_q == $past(time_q) + CNT_W'(1)));
  // R2
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(time_q));
  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    irq_o == $past(due));
endmodule

bind hart_timer htm_checker #(.HARTS(HARTS)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .bus_valid(bus_valid),
  .bus_ready(bus_ready), .bus_we(bus_we), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .time_q(time_q), .cmp_flat(cmp_flat), .irq_o(irq_o)
);

// File: tb/hart_timer_test.sv
module hart_timer_test;
  localparam int NH = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NH-1:0] irq_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] cmp_m [NH];
  logic [63:0] t_m = '0;

  always #5 clk = ~clk;

  hart_timer #(.HARTS(NH), .ADDR_W(8), .CMP_BASE(8'h40), .TIME_BASE(8'h20)) uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit we, input logic [7:0] a, input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    while (!bus_ready) @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
    r = rsp_rdata;
    chk(rsp_valid == 1'b1, "R9 response pulse", 64'(rsp_valid), 64'd1);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] r;
    xfer(1'b1, a, d, r);
    chk(r == 32'd0, "R9 write response data", 64'(r), 64'd0);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] r);
    xfer(1'b0, a, 32'd0, r);
  endtask

  task automatic wr_cmp(input int i, input bit hi, input logic [31:0] d);
    wr(8'(8'h40 + 8 * i + (hi ? 4 : 0)), d);
    if (hi) cmp_m[i][63:32] = d;
    else    cmp_m[i][31:0]  = d;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
    t_m = t_m + 64'(n);
  endtask

  function automatic logic [NH-1:0] exp_irq();
    logic [NH-1:0] e;
    for (int i = 0; i < NH; i++) e[i] = cmp_m[i] <= t_m;
    return e;
  endfunction

  function automatic logic [31:0] exp_rd(input int a);
    if (a >= 'h40 && a < 'h40 + 8 * NH) begin
      int off = a - 'h40;
      int i = off / 8;
      if (off % 8 == 0) return cmp_m[i][31:0];
      if (off % 8 == 4) return cmp_m[i][63:32];
      return 32'd0;
    end
    if (a == 'h20) return t_m[31:0];
    if (a == 'h24) return t_m[63:32];
    return 32'd0;
  endfunction

  function automatic bit mapped(input int a);
    return (a == 'h20) || (a == 'h24) ||
           (a >= 'h40 && a < 'h40 + 8 * NH && (a % 4 == 0));
  endfunction

  task automatic chk_irq(input string req);
    @(negedge clk);
    chk(irq_o == exp_irq(), req, 64'(irq_o), 64'(exp_irq()));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [63:0] t0;
    for (int i = 0; i < NH; i++) cmp_m[i] = '0;

    repeat (4) @(negedge clk);
    chk(bus_ready == 1'b0, "R1 ready low in reset", 64'(bus_ready), 64'd0);
    chk(irq_o == '0, "R1 irq low in reset", 64'(irq_o), 64'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(irq_o == exp_irq(), "R6 irq after reset with zero compare", 64'(irq_o), 64'(exp_irq()));
    rd(8'h20, r); chk(r == 32'd0, "R1 time low reset", 64'(r), 64'd0);
    rd(8'h24, r); chk(r == 32'd0, "R1 time high reset", 64'(r), 64'd0);
    for (int i = 0; i < NH; i++) begin
      rd(8'(8'h40 + 8 * i), r);     chk(r == 32'd0, "R1 compare low reset", 64'(r), 64'd0);
      rd(8'(8'h40 + 8 * i + 4), r); chk(r == 32'd0, "R1 compare high reset", 64'(r), 64'd0);
    end

    // R2 / R3: counting and time reads
    tick(10);
    rd(8'h20, r); chk(r == t_m[31:0], "R2 R3 count after ten ticks", 64'(r), t_m);
    rd(8'h24, r); chk(r == t_m[63:32], "R3 time high word", 64'(r), 64'(t_m[63:32]));
    repeat (6) @(negedge clk);
    rd(8'h20, r); chk(r == t_m[31:0], "R2 hold without tick", 64'(r), t_m);

    // R7: writes to the count are discarded
    wr(8'h20, 32'h0000_FFFF);
    wr(8'h24, 32'h0000_1234);
    rd(8'h20, r); chk(r == t_m[31:0], "R7 time low unchanged", 64'(r), t_m);
    rd(8'h24, r); chk(r == t_m[63:32], "R7 time high unchanged", 64'(r), 64'(t_m[63:32]));

    // R6 boundaries and R5 half independence, per hart
    for (int i = 0; i < NH; i++) begin
      wr_cmp(i, 1'b0, t_m[31:0] + 32'd1); chk_irq("R6 compare one above count");
      wr_cmp(i, 1'b0, t_m[31:0]);         chk_irq("R6 compare equal to count");
      wr_cmp(i, 1'b0, t_m[31:0] - 32'd1); chk_irq("R6 compare one below count");
      wr_cmp(i, 1'b0, t_m[31:0] + 32'd1);
      wr_cmp(i, 1'b1, 32'd1);             chk_irq("R6 high half raises compare");
      rd(8'(8'h40 + 8 * i), r); chk(r == t_m[31:0] + 32'd1, "R5 low kept after high write", 64'(r), 64'(cmp_m[i][31:0]));
      wr_cmp(i, 1'b0, 32'd0);             chk_irq("R6 unsigned compare with high half set");
      rd(8'(8'h40 + 8 * i + 4), r); chk(r == 32'd1, "R5 high kept after low write", 64'(r), 64'd1);
    end

    // R6 sweep: count walks across staggered compare values
    for (int i = 0; i < NH; i++) begin
      wr_cmp(i, 1'b1, 32'd0);
      wr_cmp(i, 1'b0, t_m[31:0] + 32'(2 + 3 * i));
    end
    chk_irq("R6 sweep start");
    for (int s = 0; s < 12; s++) begin
      tick(1);
      chk_irq("R6 sweep step");
    end

    // R4 / R8 / R3: full address read sweep with distinct compare values
    for (int i = 0; i < NH; i++) begin
      wr_cmp(i, 1'b0, 32'h5A00_0001 + 32'(16 * i));
      wr_cmp(i, 1'b1, 32'hC0DE_0000 + 32'(i));
    end
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), r);
      chk(r == exp_rd(a), "R4 R8 address sweep read", 64'(r), 64'(exp_rd(a)));
    end

    // R8: writes to unmapped addresses change nothing
    for (int a = 0; a < 256; a++) begin
      if (!mapped(a)) wr(8'(a), 32'hFFFF_FFFF);
    end
    for (int i = 0; i < NH; i++) begin
      rd(8'(8'h40 + 8 * i), r);     chk(r == cmp_m[i][31:0], "R8 compare low after unmapped writes", 64'(r), 64'(cmp_m[i][31:0]));
      rd(8'(8'h40 + 8 * i + 4), r); chk(r == cmp_m[i][63:32], "R8 compare high after unmapped writes", 64'(r), 64'(cmp_m[i][63:32]));
    end
    rd(8'h20, r); chk(r == t_m[31:0], "R8 count after unmapped writes", 64'(r), t_m);

    // R3: a read taken while counting returns the count of the accept cycle
    t0 = t_m;
    @(negedge clk);
    tick_en = 1'b1;
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = 8'h20;
    @(negedge clk);
    bus_valid = 1'b0;
    chk(rsp_rdata == t0[31:0] && rsp_valid, "R3 read while counting", 64'(rsp_rdata), t0);
    @(negedge clk);
    tick_en = 1'b0;
    t_m = t0 + 64'd2;
    rd(8'h20, r); chk(r == t_m[31:0], "R2 count after two ticks", 64'(r), t_m);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule